// File: doc/BRIEF.md
# Ternary Lookup Table with Priority Selection

This block holds a table of ternary words and answers one question per cycle: which stored word does a search key fall under? Each word is stored as a value together with a don't-care mask. The key is compared with every word at once. A priority stage then reduces the per-word hit lines to a single hit flag and the index of the chosen word. The result is registered and appears one cycle after the search is issued, together with a result strobe.

Words are loaded one at a time through a write port that takes an address, a value and a mask. Conflicts between several matching words are settled by word position: the lowest-numbered matching word wins. A routing-style user who loads words in order of decreasing prefix length therefore gets the most specific (longest-prefix) match. The table grows by widening the key (more ternary cells per word) and by adding words side by side.

Top module: `tlt_lookup`

## Requirements
- R1: After reset every word is empty and `res_valid`, `res_hit` and `res_index` are 0.
- R2: A key bit matches a stored bit whose mask bit (in `wr_mask`, 1 = don't care) is 1 for either key value; where the mask bit is 0 it matches only an equal key bit. A word hits only when all its bits match.
- R3: `res_valid` is 1 in exactly the cycle after a cycle with `srch_valid` at 1, and the result of that search is on `res_hit` and `res_index` in that same cycle.
- R4: When several words hit, `res_index` is the lowest index among them.
- R5: When no word hits a search, `res_hit` is 0 and `res_index` is 0.
- R6: A word that has not been written since reset never hits, whatever the key.
- R7: A write is seen by searches issued from the next cycle on; a search issued in the same cycle as a write uses the table contents before that write.
- R8: In a cycle after one with `srch_valid` at 0, `res_valid` and `res_hit` are 0.
- R9: With key 01101, a word 0110X at index 1 and a word 011XX at index 3 both hit, and the reported index is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write one word this cycle |
| wr_addr | input | IDX_W | Index of the word to write |
| wr_value | input | KEY_W | Value bits of the word |
| wr_mask | input | KEY_W | Don't-care bits of the word, 1 = don't care |
| srch_valid | input | 1 | Search request this cycle |
| srch_key | input | KEY_W | Key to look up |
| res_valid | output | 1 | Result strobe, one cycle after `srch_valid` |
| res_hit | output | 1 | At least one word matched |
| res_index | output | IDX_W | Index of the selected word, 0 on a miss |

## Verification
On every cycle the assertions check the strobe timing against the request, that a miss carries index 0, that an empty word never raises its hit line, and that the reported index is a hitting word with no lower-numbered hitting word beside it. Whether the per-bit don't-care comparison is right, whether the prefix example resolves to index 1, and whether a write issued together with a search stays invisible to it can only be shown by the bench, which sweeps every key of a small table against an arithmetic model after several loads.

// File: rtl/tlt_pkg.sv
package tlt_pkg;

  // Index width for a table of n words, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tlt_rst_sync.sv
module tlt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tlt_entry.sv
module tlt_entry #(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic [KEY_W-1:0] key,
  output logic             hit,
  output logic             valid
);

  logic [KEY_W-1:0] val_q, val_d;
  logic [KEY_W-1:0] dc_q, dc_d;
  logic             vld_q;
  logic [KEY_W-1:0] bit_ok;

  // Next state: masked value bits are stored as 0 so the word has one form.
  always_comb begin
    val_d = wr_value & ~wr_mask;
    dc_d  = wr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dc_q  <= '0;
      vld_q <= 1'b0;
    end else if (wr_sel) begin
      val_q <= val_d;
      dc_q  <= dc_d;
      vld_q <= 1'b1;
    end
  end

  // One ternary cell per bit: equal bits or a don't-care bit pass.
  always_comb begin
    bit_ok = ~(key ^ val_q) | dc_q;
    hit    = vld_q & (&bit_ok);
  end

  assign valid = vld_q;

endmodule

// File: rtl/tlt_prio_enc.sv
module tlt_prio_enc #(
  parameter int WIDTH = 16,
  parameter int IDX_W = 4
) (
  input  logic [WIDTH-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Lowest set position wins: scan from the top so lower positions overwrite.
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/tlt_lookup.sv
module tlt_lookup #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 8,
  localparam int IDX_W  = tlt_pkg::idx_w(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic             srch_valid,
  input  logic [KEY_W-1:0] srch_key,
  output logic             res_valid,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_index
);

  logic               rst_sync_n;
  logic [ENTRIES-1:0] wr_sel;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] vld_vec;
  logic               enc_any;
  logic [IDX_W-1:0]   enc_idx;

  logic               res_valid_q, res_valid_d;
  logic               res_hit_q, res_hit_d;
  logic [IDX_W-1:0]   res_index_q, res_index_d;

  tlt_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Write address decode.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      wr_sel[i] = wr_en && (wr_addr == IDX_W'(i));
    end
  end

  // M words in parallel, each a chain of KEY_W ternary cells.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_word
    tlt_entry #(
      .KEY_W (KEY_W)
    ) i_entry (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_sel   (wr_sel[g]),
      .wr_value (wr_value),
      .wr_mask  (wr_mask),
      .key      (srch_key),
      .hit      (hit_vec[g]),
      .valid    (vld_vec[g])
    );
  end

  tlt_prio_enc #(
    .WIDTH (ENTRIES),
    .IDX_W (IDX_W)
  ) i_prio_enc (
    .req (hit_vec),
    .any (enc_any),
    .idx (enc_idx)
  );

  // Result next state.
  always_comb begin
    res_valid_d = srch_valid;
    res_hit_d   = srch_valid && enc_any;
    res_index_d = (srch_valid && enc_any) ? enc_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid_q <= 1'b0;
      res_hit_q   <= 1'b0;
      res_index_q <= '0;
    end else begin
      res_valid_q <= res_valid_d;
      res_hit_q   <= res_hit_d;
      res_index_q <= res_index_d;
    end
  end

  assign res_valid = res_valid_q;
  assign res_hit   = res_hit_q;
  assign res_index = res_index_q;

endmodule

// File: rtl/tlt_lookup_chk.sv
module tlt_lookup_chk #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 8,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               srch_valid,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] vld_vec,
  input logic               res_valid,
  input logic               res_hit,
  input logic [IDX_W-1:0]   res_index
);

  logic [ENTRIES-1:0] hv_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hv_q <= '0;
    end else begin
      hv_q <= srch_valid ? hit_vec : '0;
    end
  end

  assert_strobe_follows_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    srch_valid |=> res_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !srch_valid |=> (!res_valid && !res_hit));

  assert_miss_index_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !res_hit |-> (res_index == '0));

  assert_empty_never_hits_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit_vec & ~vld_vec) == '0);

  assert_hit_flag_matches_lines_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid |-> (res_hit == (|hv_q)));

  assert_lowest_winner_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_hit |-> (hv_q[res_index] &&
                 ((hv_q & ((ENTRIES'(1) << res_index) - ENTRIES'(1))) == '0)));

endmodule

bind tlt_lookup tlt_lookup_chk #(
  .ENTRIES (ENTRIES),
  .KEY_W   (KEY_W),
  .IDX_W   (IDX_W)
) i_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .srch_valid (srch_valid),
  .hit_vec    (hit_vec),
  .vld_vec    (vld_vec),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .res_index  (res_index)
);

// File: tb/test_tlt_lookup.sv
module test_tlt_lookup;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 8;
  localparam int KEY_W      = 5;
  localparam int IDX_W      = 3;
  localparam int NKEYS      = 1 << KEY_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en;
  logic [IDX_W-1:0] wr_addr;
  logic [KEY_W-1:0] wr_value;
  logic [KEY_W-1:0] wr_mask;
  logic             srch_valid;
  logic [KEY_W-1:0] srch_key;
  logic             res_valid;
  logic             res_hit;
  logic [IDX_W-1:0] res_index;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [KEY_W-1:0] m_val [ENTRIES];
  logic [KEY_W-1:0] m_msk [ENTRIES];
  logic             m_vld [ENTRIES];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlt_lookup #(
    .ENTRIES (ENTRIES),
    .KEY_W   (KEY_W)
  ) i_tlt_lookup (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_value   (wr_value),
    .wr_mask    (wr_mask),
    .srch_valid (srch_valid),
    .srch_key   (srch_key),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_index  (res_index)
  );

  function automatic void model(input logic [KEY_W-1:0] k,
                                output logic h, output logic [IDX_W-1:0] ix);
    h  = 1'b0;
    ix = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (m_vld[e] && (((k ^ m_val[e]) & ~m_msk[e]) == '0)) begin
        h  = 1'b1;
        ix = IDX_W'(e);
      end
    end
  endfunction

  task automatic check(input string req, input logic v, input logic h,
                       input logic [IDX_W-1:0] ix);
    checks++;
    if (res_valid !== v || res_hit !== h || res_index !== ix) begin
      errors++;
      $display("FAIL %s: got valid=%b hit=%b index=%0d, expected valid=%b hit=%b index=%0d",
               req, res_valid, res_hit, res_index, v, h, ix);
    end
  endtask

  task automatic write_word(input int a, input logic [KEY_W-1:0] v,
                            input logic [KEY_W-1:0] m);
    @(negedge clk);
    wr_en    = 1'b1;
    wr_addr  = IDX_W'(a);
    wr_value = v;
    wr_mask  = m;
    @(negedge clk);
    wr_en    = 1'b0;
    m_val[a] = v;
    m_msk[a] = m;
    m_vld[a] = 1'b1;
  endtask

  task automatic search(input logic [KEY_W-1:0] k, input string req);
    logic             eh;
    logic [IDX_W-1:0] ei;
    model(k, eh, ei);
    @(negedge clk);
    srch_valid = 1'b1;
    srch_key   = k;
    @(negedge clk);
    srch_valid = 1'b0;
    check(req, 1'b1, eh, ei);
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < NKEYS; k++) begin
      search(KEY_W'(k), req);
    end
  endtask

  initial begin
    rst_n      = 1'b0;
    wr_en      = 1'b0;
    wr_addr    = '0;
    wr_value   = '0;
    wr_mask    = '0;
    srch_valid = 1'b0;
    srch_key   = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      m_val[e] = '0;
      m_msk[e] = '0;
      m_vld[e] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: outputs cleared after reset
    check("R1 reset state", 1'b0, 1'b0, '0);

    // R6 / R5: empty table misses every key
    sweep("R6 empty table");

    // R9: prefix example, 0110X at 1 and 011XX at 3
    write_word(1, 5'b01100, 5'b00001);
    write_word(3, 5'b01100, 5'b00011);
    search(5'b01101, "R9 prefix example");
    checks++;
    if (res_index !== 3'd1 || res_hit !== 1'b1) begin
      errors++;
      $display("FAIL R9: got hit=%b index=%0d, expected hit=1 index=1", res_hit, res_index);
    end
    search(5'b01110, "R4 only wider word hits");
    search(5'b10110, "R5 miss gives index 0");

    // R8: idle cycle after a search drops strobe and hit
    @(negedge clk);
    check("R8 idle after search", 1'b0, 1'b0, '0);

    // R7: write and search in the same cycle see the old table
    @(negedge clk);
    wr_en      = 1'b1;
    wr_addr    = '0;
    wr_value   = 5'b10110;
    wr_mask    = '0;
    srch_valid = 1'b1;
    srch_key   = 5'b10110;
    @(negedge clk);
    wr_en      = 1'b0;
    srch_valid = 1'b0;
    check("R7 same-cycle search sees old table", 1'b1, 1'b0, '0);
    m_val[0] = 5'b10110;
    m_msk[0] = '0;
    m_vld[0] = 1'b1;
    search(5'b10110, "R7 next-cycle search sees write");

    // R2 / R4: sweep with partial table
    sweep("R2 partial table sweep");

    // R2 / R4: fill all words with varied values and masks
    for (int e = 0; e < ENTRIES; e++) begin
      write_word(e, KEY_W'((e * 11 + 3) % NKEYS), KEY_W'((1 << (e % 4)) - 1));
    end
    sweep("R2 full table sweep");

    // R4: exact word above a full wildcard word
    write_word(6, 5'b00111, 5'b00000);
    write_word(7, 5'b00000, 5'b11111);
    sweep("R4 wildcard at top index");

    // R3: back-to-back searches each yield a strobe
    @(negedge clk);
    srch_valid = 1'b1;
    srch_key   = 5'b00111;
    @(negedge clk);
    srch_key   = 5'b11000;
    begin
      logic h; logic [IDX_W-1:0] ix;
      model(5'b00111, h, ix);
      check("R3 first of two back-to-back", 1'b1, h, ix);
      @(negedge clk);
      srch_valid = 1'b0;
      model(5'b11000, h, ix);
      check("R3 second of two back-to-back", 1'b1, h, ix);
    end
    @(negedge clk);
    check("R8 idle after burst", 1'b0, 1'b0, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule